// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps the status word of one channel of a scatter-gather DMA card and folds the channel's interrupt sources into a single request line. It latches sticky events from the read and write DMA engines: bus aborts, descriptor direction mismatches and list completions. It also latches a transmit FIFO almost-empty event. Idle indications and external FIFO flags pass through as live bits, so software sees the whole picture in one read.

Software reads the status word at any time. It clears a sticky bit by writing a one to that bit position. Two combined interrupt views are kept. The local view is the OR of the masked local sources and does not include DMA or the master enable. The final view adds the DMA completion bits and is gated by the master enable. The final view, registered, drives the interrupt output.

Top module: `dma_chan_stat`

## Requirements
- R1: Status bit 0 (read error) sets on a read-engine target abort, master abort or descriptor direction mismatch. Status bit 1 (write error) sets on the same three write-engine sources. Each source sets only its own engine's bit.
- R2: Latched bits 0 to 4 reset to 0 and hold once set. A bit clears in the cycle after a write with sw_wr_i high and a one in that bit of sw_wdata_i. Writing a zero to a bit leaves it unchanged.
- R3: Status bit 2 (read list done) and bit 3 (write list done) latch when the matching list-completion pulse arrives.
- R4: Status bit 4 latches on a rising edge of the transmit FIFO almost-empty level. While that level stays high it does not set again after it is cleared.
- R5: Status bits 5, 6 and 7 follow the burst-in idle, burst-out idle and transmit idle inputs in the same cycle.
- R6: Status bit 8 follows the external FIFO empty flag and bit 9 follows the external FIFO full flag.
- R7: Status bit 10 is the OR over all sources of each local source ANDed with its mask bit. It does not depend on the master enable or on DMA state.
- R8: Status bit 11 is the master enable ANDed with the OR of bit 10, bit 2 and bit 3.
- R9: irq_o equals status bit 11 one clock earlier, and it is 0 while reset is asserted.
- R10: If a set event and a write-one-to-clear hit the same latched bit in the same cycle, the bit ends up set.
- R11: Writes have no effect on bits 5 to 11, and bits 12 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tabort_i | input | 1 | Read engine bus target abort |
| rd_mabort_i | input | 1 | Read engine bus master abort |
| rd_dir_bad_i | input | 1 | Read descriptor direction mismatch |
| rd_list_done_i | input | 1 | Read scatter-gather list finished |
| wr_tabort_i | input | 1 | Write engine bus target abort |
| wr_mabort_i | input | 1 | Write engine bus master abort |
| wr_dir_bad_i | input | 1 | Write descriptor direction mismatch |
| wr_list_done_i | input | 1 | Write scatter-gather list finished |
| bi_idle_i | input | 1 | Burst-in machine idle |
| bo_idle_i | input | 1 | Burst-out machine idle |
| tx_idle_i | input | 1 | Transmit machine idle |
| xfifo_empty_i | input | 1 | External FIFO holds no words |
| xfifo_full_i | input | 1 | External FIFO has no room |
| tx_ae_lvl_i | input | 1 | Transmit FIFO at or below almost-empty level |
| loc_src_i | input | NLOC | Local interrupt sources |
| loc_mask_i | input | NLOC | Local interrupt enables |
| mie_i | input | 1 | Master interrupt enable |
| sw_wr_i | input | 1 | Software write strobe to the status word |
| sw_wdata_i | input | DATA_W | Write data (one clears a latched bit) |
| stat_o | output | DATA_W | Status word as read by software |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each error source of each engine is pulsed alone and in every combination. This shows that every source reaches only its own engine's bit, and that the bit survives idle cycles and zero writes and then clears with a one. The local interrupt is swept over all source and mask pairs with the master enable off and on. This separates the pre-enable view from the gated view and checks the one-cycle lag of the output line. Directed cases cover a set colliding with a clear, a clear while the almost-empty level stays high, list-completion interrupts through the enable, and writes aimed at the read-only bits while the live inputs sweep all their values.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
   // Layout of the channel status word
   localparam int unsigned B_RD_ERR   = 0;
   localparam int unsigned B_WR_ERR   = 1;
   localparam int unsigned B_RD_DONE  = 2;
   localparam int unsigned B_WR_DONE  = 3;
   localparam int unsigned B_TX_AE    = 4;
   localparam int unsigned B_BI_IDLE  = 5;
   localparam int unsigned B_BO_IDLE  = 6;
   localparam int unsigned B_TX_IDLE  = 7;
   localparam int unsigned B_XF_EMPTY = 8;
   localparam int unsigned B_XF_FULL  = 9;
   localparam int unsigned B_LOC_IRQ  = 10;
   localparam int unsigned B_CH_IRQ   = 11;
   localparam int unsigned STAT_BITS  = 12;
   // sticky bits occupy positions 0 .. N_LAT-1
   localparam int unsigned N_LAT      = 5;
   // error sources per engine: target abort, master abort, direction
   localparam int unsigned N_ERR_SRC  = 3;
   localparam int unsigned N_ENG      = 2;
endpackage

// File: rtl/dsa_w1c_bank.sv
module dsa_w1c_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dsa_w1c_bank: N must be at least 1");
      end
      for (genvar g = 0; g < N; g++) begin : g_bit
         logic q;
         // set has priority over a simultaneous clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i[g] | (q & ~clr_i[g]);
         end
         assign q_o[g] = q;
      end
   endgenerate
endmodule

// File: rtl/dsa_err_merge.sv
module dsa_err_merge #(
   parameter int unsigned NENG = 2,
   parameter int unsigned NSRC = 3
) (
   input  logic [NENG*NSRC-1:0] src_i,
   output logic [NENG-1:0]      err_o
);
   generate
      if (NENG < 1 || NSRC < 1) begin : g_bad_cfg
         $error("dsa_err_merge: NENG and NSRC must be nonzero");
      end
      for (genvar e = 0; e < NENG; e++) begin : g_eng
         assign err_o[e] = |src_i[e*NSRC +: NSRC];
      end
   endgenerate
endmodule

// File: rtl/dsa_edge_det.sv
module dsa_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end
   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dsa_irq_comb.sv
module dsa_irq_comb #(
   parameter int unsigned NLOC = 4,
   parameter int unsigned NDMA = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NLOC-1:0] loc_src_i,
   input  logic [NLOC-1:0] loc_mask_i,
   input  logic [NDMA-1:0] dma_done_i,
   input  logic            mie_i,
   output logic            loc_irq_o,
   output logic            ch_irq_o,
   output logic            irq_o
);
   logic [NLOC-1:0] masked;
   logic            pre_enable;

   generate
      if (NLOC < 1) begin : g_bad_nloc
         $error("dsa_irq_comb: NLOC must be at least 1");
      end
      for (genvar i = 0; i < NLOC; i++) begin : g_mask
         assign masked[i] = loc_src_i[i] & loc_mask_i[i];
      end
   endgenerate

   assign loc_irq_o  = |masked;
   assign pre_enable = loc_irq_o | (|dma_done_i);
   assign ch_irq_o   = mie_i & pre_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= ch_irq_o;
   end
endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
   import dma_stat_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NLOC    = 4,
   parameter bit          AE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_tabort_i,
   input  logic              rd_mabort_i,
   input  logic              rd_dir_bad_i,
   input  logic              rd_list_done_i,
   input  logic              wr_tabort_i,
   input  logic              wr_mabort_i,
   input  logic              wr_dir_bad_i,
   input  logic              wr_list_done_i,
   input  logic              bi_idle_i,
   input  logic              bo_idle_i,
   input  logic              tx_idle_i,
   input  logic              xfifo_empty_i,
   input  logic              xfifo_full_i,
   input  logic              tx_ae_lvl_i,
   input  logic [NLOC-1:0]   loc_src_i,
   input  logic [NLOC-1:0]   loc_mask_i,
   input  logic              mie_i,
   input  logic              sw_wr_i,
   input  logic [DATA_W-1:0] sw_wdata_i,
   output logic [DATA_W-1:0] stat_o,
   output logic              irq_o
);
   localparam int unsigned N_ESRC = N_ENG * N_ERR_SRC;

   generate
      if (DATA_W < STAT_BITS) begin : g_bad_width
         $error("dma_chan_stat: DATA_W too small for the status word");
      end
      if (NLOC < 1) begin : g_bad_nloc
         $error("dma_chan_stat: NLOC must be at least 1");
      end
   endgenerate

   // error sources, read engine in the low group
   logic [N_ESRC-1:0] err_src;
   logic [N_ENG-1:0]  err_evt;
   assign err_src = {wr_dir_bad_i, wr_mabort_i, wr_tabort_i,
                     rd_dir_bad_i, rd_mabort_i, rd_tabort_i};

   dsa_err_merge #(.NENG(N_ENG), .NSRC(N_ERR_SRC)) u_err (
      .src_i (err_src),
      .err_o (err_evt)
   );

   // almost-empty event: edge or level variant
   logic ae_evt;
   generate
      if (AE_EDGE) begin : g_ae_edge
         dsa_edge_det u_ae (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (tx_ae_lvl_i),
            .rise_o (ae_evt)
         );
      end else begin : g_ae_level
         assign ae_evt = tx_ae_lvl_i;
      end
   endgenerate

   // sticky bank
   logic [N_LAT-1:0] lat_set;
   logic [N_LAT-1:0] lat_clr;
   logic [N_LAT-1:0] lat_q;

   always_comb begin
      lat_set            = '0;
      lat_set[B_RD_ERR]  = err_evt[0];
      lat_set[B_WR_ERR]  = err_evt[1];
      lat_set[B_RD_DONE] = rd_list_done_i;
      lat_set[B_WR_DONE] = wr_list_done_i;
      lat_set[B_TX_AE]   = ae_evt;
   end

   assign lat_clr = {N_LAT{sw_wr_i}} & sw_wdata_i[N_LAT-1:0];

   logic unused_wdata;
   assign unused_wdata = ^sw_wdata_i[DATA_W-1:N_LAT];

   dsa_w1c_bank #(.N(N_LAT)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lat_set),
      .clr_i (lat_clr),
      .q_o   (lat_q)
   );

   // interrupt combining
   logic loc_irq;
   logic ch_irq;

   dsa_irq_comb #(.NLOC(NLOC), .NDMA(N_ENG)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .loc_src_i  (loc_src_i),
      .loc_mask_i (loc_mask_i),
      .dma_done_i ({lat_q[B_WR_DONE], lat_q[B_RD_DONE]}),
      .mie_i      (mie_i),
      .loc_irq_o  (loc_irq),
      .ch_irq_o   (ch_irq),
      .irq_o      (irq_o)
   );

   // status word assembly
   always_comb begin
      stat_o               = '0;
      stat_o[N_LAT-1:0]    = lat_q;
      stat_o[B_BI_IDLE]    = bi_idle_i;
      stat_o[B_BO_IDLE]    = bo_idle_i;
      stat_o[B_TX_IDLE]    = tx_idle_i;
      stat_o[B_XF_EMPTY]   = xfifo_empty_i;
      stat_o[B_XF_FULL]    = xfifo_full_i;
      stat_o[B_LOC_IRQ]    = loc_irq;
      stat_o[B_CH_IRQ]     = ch_irq;
   end
endmodule

// File: rtl/dma_chan_stat_chk.sv
module dma_chan_stat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_tabort_i,
   input logic       rd_mabort_i,
   input logic       rd_dir_bad_i,
   input logic       rd_list_done_i,
   input logic       wr_tabort_i,
   input logic       mie_i,
   input logic       sw_wr_i,
   input logic [1:0] wd_lo,
   input logic [2:0] st_lo,
   input logic       st_irq,
   input logic       irq_o
);
   // R1: any read-engine error source sets the read error bit
   a_r1_rd_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_tabort_i || rd_mabort_i || rd_dir_bad_i) |=> st_lo[0]);

   // R2: a set error bit holds unless cleared by a one
   a_r2_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st_lo[0] && !(sw_wr_i && wd_lo[0])) |=> st_lo[0]);

   // R2: write-one clears when no new event
   a_r2_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_i && wd_lo[0] && !(rd_tabort_i || rd_mabort_i || rd_dir_bad_i))
      |=> !st_lo[0]);

   // R3: list completion latches
   a_r3_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
      rd_list_done_i |=> st_lo[2]);

   // R10: set wins against a clear
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tabort_i && sw_wr_i && wd_lo[1]) |=> st_lo[1]);

   // R8: no channel request without master enable
   a_r8_mie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !mie_i |-> !st_irq);

   // R9: output line follows the final view one cycle later
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      st_irq |=> irq_o);
   a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !st_irq |=> !irq_o);

   // R9: low while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r9_low_in_reset: assert (!irq_o);
      end
   end
endmodule

bind dma_chan_stat dma_chan_stat_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_tabort_i    (rd_tabort_i),
   .rd_mabort_i    (rd_mabort_i),
   .rd_dir_bad_i   (rd_dir_bad_i),
   .rd_list_done_i (rd_list_done_i),
   .wr_tabort_i    (wr_tabort_i),
   .mie_i          (mie_i),
   .sw_wr_i        (sw_wr_i),
   .wd_lo          (sw_wdata_i[1:0]),
   .st_lo          (stat_o[2:0]),
   .st_irq         (stat_o[11]),
   .irq_o          (irq_o)
);

// File: tb/dma_chan_stat_bench.sv
`timescale 1ns/1ps
module dma_chan_stat_bench;
   localparam int unsigned DW = 16;
   localparam int unsigned NL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_tab = 0, rd_mab = 0, rd_dir = 0, rd_done = 0;
   logic wr_tab = 0, wr_mab = 0, wr_dir = 0, wr_done = 0;
   logic bi_idle = 0, bo_idle = 0, tx_idle = 0, xf_empty = 0, xf_full = 0;
   logic tx_ae = 0;
   logic [NL-1:0] loc_src = '0, loc_mask = '0;
   logic mie = 0, sw_wr = 0;
   logic [DW-1:0] sw_wdata = '0;
   logic [DW-1:0] stat;
   logic irq;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   dma_chan_stat #(.DATA_W(DW), .NLOC(NL)) u_dma_chan_stat (
      .clk(clk), .rst_n(rst_n),
      .rd_tabort_i(rd_tab), .rd_mabort_i(rd_mab), .rd_dir_bad_i(rd_dir),
      .rd_list_done_i(rd_done),
      .wr_tabort_i(wr_tab), .wr_mabort_i(wr_mab), .wr_dir_bad_i(wr_dir),
      .wr_list_done_i(wr_done),
      .bi_idle_i(bi_idle), .bo_idle_i(bo_idle), .tx_idle_i(tx_idle),
      .xfifo_empty_i(xf_empty), .xfifo_full_i(xf_full), .tx_ae_lvl_i(tx_ae),
      .loc_src_i(loc_src), .loc_mask_i(loc_mask), .mie_i(mie),
      .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
      .stat_o(stat), .irq_o(irq)
   );

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_err(input int eng, input logic [2:0] s);
      if (eng == 0) {rd_dir, rd_mab, rd_tab} = s;
      else          {wr_dir, wr_mab, wr_tab} = s;
   endtask

   task automatic w1c(input logic [DW-1:0] d);
      sw_wr = 1'b1; sw_wdata = d;
      step;
      sw_wr = 1'b0; sw_wdata = '0;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run;
   end

   initial begin
      // reset behaviour: R8 combinational view live, R9 line low
      mie = 1'b1; loc_src = '1; loc_mask = '1;
      #1;
      chk("R8 view during reset", 32'(stat[11]), 1);
      chk("R9 irq low in reset", 32'(irq), 0);
      step; step; step;
      chk("R9 irq low in reset later", 32'(irq), 0);
      chk("R2 latched bits reset", 32'(stat[4:0]), 0);
      mie = 0; loc_src = '0; loc_mask = '0;
      rst_n = 1'b1;
      step;
      chk("R9 irq idle after reset", 32'(irq), 0);

      // R1 / R2: every error source combination per engine
      for (int eng = 0; eng < 2; eng++) begin
         for (int s = 1; s < 8; s++) begin
            set_err(eng, 3'(s));
            step;
            set_err(eng, 3'b000);
            chk("R1 error bit sets", 32'(stat[eng]), 1);
            chk("R1 other engine untouched", 32'(stat[1-eng]), 0);
            step;
            chk("R2 error bit holds", 32'(stat[eng]), 1);
            w1c('0);
            chk("R2 zero write keeps bit", 32'(stat[eng]), 1);
            w1c(DW'(1) << eng);
            chk("R2 one write clears bit", 32'(stat[eng]), 0);
         end
      end

      // R10: event and clear in the same cycle
      wr_tab = 1'b1; sw_wr = 1'b1; sw_wdata = DW'(2);
      step;
      wr_tab = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
      chk("R10 set wins from clear", 32'(stat[1]), 1);
      wr_mab = 1'b1; sw_wr = 1'b1; sw_wdata = DW'(2);
      step;
      wr_mab = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
      chk("R10 set wins while set", 32'(stat[1]), 1);
      w1c(DW'(2));
      chk("R2 cleared after collision", 32'(stat[1]), 0);

      // R3 / R8 / R9: list completion through the master enable
      mie = 1'b1;
      rd_done = 1'b1;
      step;
      rd_done = 1'b0;
      chk("R3 read done latches", 32'(stat[2]), 1);
      chk("R8 done raises channel irq", 32'(stat[11]), 1);
      chk("R7 done not in local view", 32'(stat[10]), 0);
      step;
      chk("R9 irq follows one cycle later", 32'(irq), 1);
      mie = 1'b0;
      #1;
      chk("R8 master enable gates", 32'(stat[11]), 0);
      step;
      chk("R9 irq drops", 32'(irq), 0);
      chk("R2 done bit still held", 32'(stat[2]), 1);
      w1c(DW'(4));
      chk("R2 done bit clears", 32'(stat[2]), 0);
      mie = 1'b1;
      wr_done = 1'b1;
      step;
      wr_done = 1'b0;
      chk("R3 write done latches", 32'(stat[3]), 1);
      chk("R8 write done raises irq", 32'(stat[11]), 1);
      w1c(DW'(8));
      chk("R8 irq gone after clear", 32'(stat[11]), 0);
      step;
      chk("R9 irq low after clear", 32'(irq), 0);
      mie = 1'b0;

      // R4: almost-empty rising edge
      tx_ae = 1'b1;
      step;
      chk("R4 ae latches on rise", 32'(stat[4]), 1);
      w1c(DW'(16));
      chk("R4 clear while level high", 32'(stat[4]), 0);
      step;
      chk("R4 no re-set while high", 32'(stat[4]), 0);
      tx_ae = 1'b0;
      step;
      tx_ae = 1'b1;
      step;
      chk("R4 sets on new rise", 32'(stat[4]), 1);
      tx_ae = 1'b0;
      w1c(DW'(16));
      chk("R4 cleared", 32'(stat[4]), 0);

      // R5 / R6: live bits, all combinations
      for (int v = 0; v < 32; v++) begin
         {xf_full, xf_empty, tx_idle, bo_idle, bi_idle} = 5'(v);
         #1;
         chk("R5 R6 live bits follow inputs", 32'(stat[9:5]), 32'(v));
      end

      // R11: writes to read-only bits ignored
      {xf_full, xf_empty, tx_idle, bo_idle, bi_idle} = 5'b10101;
      mie = 1'b1; loc_src = 4'b0001; loc_mask = 4'b0001;
      sw_wr = 1'b1; sw_wdata = '1;
      step;
      chk("R11 live bits unchanged by write", 32'(stat[9:5]), 32'h15);
      chk("R11 combined bits unchanged", 32'(stat[11:10]), 3);
      sw_wr = 1'b0; sw_wdata = '0;
      #1;
      chk("R11 upper bits zero", 32'(stat[DW-1:12]), 0);
      chk("R2 latched bits stay clear", 32'(stat[4:0]), 0);
      loc_src = '0; loc_mask = '0; mie = 0;
      step;

      // R7 / R8 / R9: local sweep over source, mask and enable
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 16; k++) begin
               logic exp_loc;
               mie = m[0]; loc_src = 4'(s); loc_mask = 4'(k);
               exp_loc = ((s & k) != 0);
               #1;
               chk("R7 local view", 32'(stat[10]), 32'(exp_loc));
               chk("R8 channel view", 32'(stat[11]), 32'(exp_loc & m[0]));
               step;
               chk("R9 registered line", 32'(irq), 32'(exp_loc & m[0]));
            end
         end
      end

      finish_run;
   end
endmodule